// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segmented logical address into a flat physical address. A request carries a 7-bit segment number and a 16-bit offset. The segment number picks one of 64 descriptors. Each descriptor holds a 16-bit base counted in 256-byte blocks, a length counted in 256-byte blocks, and three access attributes: write-protected, closed to DMA masters, and reserved for system mode.

The physical address is the base shifted up by eight bits plus the full offset, wrapped to 24 bits. Because the base is block-aligned, the low offset byte reaches the output unchanged. Each request is also checked against the descriptor's length and attributes. A request that breaks a rule raises a one-cycle segment-trap output in place of a forwarded access.

A host loads descriptors through a single-cycle write port. Results appear one clock after the request, from registers.

Top module: `seg_xlate_unit`

## Requirements
- R1: For an allowed request, rsp_addr = (base × 256 + offset) mod 2^24, and rsp_addr[7:0] equals offset[7:0].
- R2: rsp_valid is high in exactly the cycle after a cycle in which req_valid was high.
- R3: A request whose offset[15:8] is greater than the segment's length field traps; offset[15:8] equal to the length is allowed. A length of 8'hFF permits the full 64 KB.
- R4: A write (req_write=1) to a segment whose write-protect bit is set traps; a read from it is allowed.
- R5: A DMA request (req_dma=1) to a segment whose no-DMA bit is set traps.
- R6: A request with req_sys=0 to a segment whose system-only bit is set traps; with req_sys=1 it is allowed.
- R7: Any segment number of 64 or above traps, whatever the descriptor contents.
- R8: When seg_trap is high, rsp_valid is high, rsp_fwd is low and rsp_addr is zero. For an allowed request, rsp_fwd is high and seg_trap is low.
- R9: After reset all outputs are low, and every descriptor has base 0, length 0 and all attributes clear.
- R10: A descriptor write in one cycle affects requests from the next cycle on. A request in the same cycle as the write uses the old descriptor.
- R11: In a cycle after no request, rsp_valid, rsp_fwd and seg_trap are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 6 | Descriptor index to write |
| cfg_base | input | 16 | Block base (256-byte units) |
| cfg_len | input | 8 | Highest allowed offset block |
| cfg_wprot | input | 1 | Write-protect attribute |
| cfg_nodma | input | 1 | No-DMA attribute |
| cfg_sysonly | input | 1 | System-only attribute |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 7 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_write | input | 1 | 1 = write access |
| req_dma | input | 1 | 1 = access from a DMA master |
| req_sys | input | 1 | 1 = issued in system mode |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_fwd | output | 1 | Access is allowed and passed on to memory |
| rsp_addr | output | 24 | Physical address (zero on trap) |
| seg_trap | output | 1 | Segmentation violation pulse |

## Verification
Translation is tried with a zero base, a mid-range base, and the all-ones base, where the sum wraps past 24 bits. This shows whether the base is shifted by a full byte and whether the wrap is kept. Each trap rule is hit both on the legal side of its boundary and on the illegal side: length equal versus one block beyond, read versus write, CPU versus DMA, system versus user, and segment 63 versus 64 and 127. This tells a wrong compare sense apart from a missing check. A write and a request in the same cycle, with a different base written, shows whether the table is read before or after the update.

// File: rtl/segxl_pkg.sv
`timescale 1ns/1ps
package segxl_pkg;
  localparam int SEG_W  = 7;
  localparam int OFF_W  = 16;
  localparam int BLK_W  = 8;
  localparam int BASE_W = 16;
  localparam int NSEG   = 64;
  localparam int SEL_W  = $clog2(NSEG);
  localparam int LEN_W  = OFF_W - BLK_W;
  localparam int PA_W   = BASE_W + BLK_W;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic              wprot;
    logic              nodma;
    logic              sysonly;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_table.sv
`timescale 1ns/1ps
module seg_desc_table
  import segxl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  seg_desc_t        wr_desc,
  input  logic [SEL_W-1:0] rd_sel,
  output seg_desc_t        rd_desc
);
  seg_desc_t ent_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic      ld;
    seg_desc_t ent_d;
    always_comb begin
      ld    = wr_en && (wr_sel == SEL_W'(g));
      ent_d = ld ? wr_desc : ent_q[g];
    end
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) ent_q[g] <= '0;
      else         ent_q[g] <= ent_d;
    end
  end

  assign rd_desc = ent_q[rd_sel];

  // R10: a write is stored and visible on the next cycle
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |=> ent_q[$past(wr_sel)] == $past(wr_desc));
endmodule

// File: rtl/seg_addr_calc.sv
`timescale 1ns/1ps
module seg_addr_calc
  import segxl_pkg::*;
(
  input  logic [BASE_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [PA_W-1:0]   paddr
);
  logic [PA_W-1:0] base_sh;
  logic [PA_W-1:0] off_ext;
  always_comb begin
    base_sh = {base, {BLK_W{1'b0}}};
    off_ext = PA_W'(off);
    paddr   = base_sh + off_ext;
  end

  // R1: block-aligned base leaves the low byte untouched
  always_comb begin
    assert_low_byte_R1: assert (paddr[BLK_W-1:0] == off[BLK_W-1:0]);
  end
endmodule

// File: rtl/seg_prot_check.sv
`timescale 1ns/1ps
module seg_prot_check
  import segxl_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [LEN_W-1:0] off_blk,
  input  seg_desc_t        desc,
  input  logic             is_write,
  input  logic             is_dma,
  input  logic             is_sys,
  output logic             viol
);
  logic bad_seg, bad_len, bad_wr, bad_dma, bad_mode;
  always_comb begin
    bad_seg  = (seg >= SEG_W'(NSEG));
    bad_len  = (off_blk > desc.len);
    bad_wr   = desc.wprot   && is_write;
    bad_dma  = desc.nodma   && is_dma;
    bad_mode = desc.sysonly && !is_sys;
    viol     = bad_seg | bad_len | bad_wr | bad_dma | bad_mode;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
  import segxl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_sel,
  input  logic [15:0] cfg_base,
  input  logic [7:0]  cfg_len,
  input  logic        cfg_wprot,
  input  logic        cfg_nodma,
  input  logic        cfg_sysonly,
  input  logic        req_valid,
  input  logic [6:0]  req_seg,
  input  logic [15:0] req_off,
  input  logic        req_write,
  input  logic        req_dma,
  input  logic        req_sys,
  output logic        rsp_valid,
  output logic        rsp_fwd,
  output logic [23:0] rsp_addr,
  output logic        seg_trap
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  seg_desc_t wr_desc, cur_desc;
  assign wr_desc = '{base: cfg_base, len: cfg_len, wprot: cfg_wprot,
                     nodma: cfg_nodma, sysonly: cfg_sysonly};

  seg_desc_table u_tab (
    .clk(clk), .rst_ns(rst_ns), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_desc(wr_desc), .rd_sel(req_seg[SEL_W-1:0]), .rd_desc(cur_desc));

  logic [PA_W-1:0] pa;
  seg_addr_calc u_add (.base(cur_desc.base), .off(req_off), .paddr(pa));

  logic viol;
  seg_prot_check u_chk (
    .seg(req_seg), .off_blk(req_off[OFF_W-1:BLK_W]), .desc(cur_desc),
    .is_write(req_write), .is_dma(req_dma), .is_sys(req_sys), .viol(viol));

  // next state
  logic            vld_d, fwd_d, trap_d;
  logic [PA_W-1:0] addr_d;
  always_comb begin
    vld_d  = req_valid;
    trap_d = req_valid && viol;
    fwd_d  = req_valid && !viol;
    addr_d = fwd_d ? pa : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid <= 1'b0;
      rsp_fwd   <= 1'b0;
      seg_trap  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= vld_d;
      rsp_fwd   <= fwd_d;
      seg_trap  <= trap_d;
      rsp_addr  <= addr_d;
    end
  end

  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !rsp_valid && !rsp_fwd && !seg_trap);
  assert_trap_has_valid_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    seg_trap |-> rsp_valid && !rsp_fwd && rsp_addr == '0);
  assert_bad_seg_traps_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_seg >= 7'd64) |=> seg_trap);
  assert_fwd_excl_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> $countones({rsp_fwd, seg_trap}) == 1);
endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_we, cfg_wprot, cfg_nodma, cfg_sysonly;
  logic [5:0] cfg_sel; logic [15:0] cfg_base; logic [7:0] cfg_len;
  logic req_valid, req_write, req_dma, req_sys;
  logic [6:0] req_seg; logic [15:0] req_off;
  logic rsp_valid, rsp_fwd, seg_trap; logic [23:0] rsp_addr;

  seg_xlate_unit u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_desc(input [5:0] s, input [15:0] b, input [7:0] l,
                         input wp, input nd, input so);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_base = b; cfg_len = l;
    cfg_wprot = wp; cfg_nodma = nd; cfg_sysonly = so;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // drive at negedge, result is registered at next posedge, sample next negedge
  task automatic issue(input [6:0] s, input [15:0] o, input w, input d, input y);
    @(negedge clk);
    req_valid = 1; req_seg = s; req_off = o; req_write = w; req_dma = d; req_sys = y;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(string req, input [23:0] ea, input et);
    chk(req, {31'd0, rsp_valid}, 1);
    chk(req, {31'd0, seg_trap}, {31'd0, et});
    chk(req, {31'd0, rsp_fwd}, {31'd0, !et});
    chk(req, {8'd0, rsp_addr}, {8'd0, ea});
  endtask

  // seg, off, write, dma, sys, expected addr, expected trap
  localparam int NV = 12;
  localparam logic [50:0] VEC [NV] = '{
    {7'd0,   16'hABCD, 1'b0,1'b0,1'b0, 24'h00ABCD, 1'b0},
    {7'd5,   16'h0F77, 1'b0,1'b0,1'b0, 24'h124377, 1'b0},
    {7'd5,   16'h1000, 1'b0,1'b0,1'b0, 24'h000000, 1'b1},
    {7'd5,   16'h0100, 1'b1,1'b0,1'b0, 24'h000000, 1'b1},
    {7'd10,  16'h0155, 1'b0,1'b0,1'b0, 24'h000055, 1'b0},
    {7'd10,  16'h0000, 1'b0,1'b1,1'b0, 24'h000000, 1'b1},
    {7'd63,  16'h0042, 1'b0,1'b0,1'b1, 24'h800042, 1'b0},
    {7'd63,  16'h0042, 1'b0,1'b0,1'b0, 24'h000000, 1'b1},
    {7'd63,  16'h0100, 1'b0,1'b0,1'b1, 24'h000000, 1'b1},
    {7'd64,  16'h0000, 1'b0,1'b0,1'b1, 24'h000000, 1'b1},
    {7'd127, 16'h0001, 1'b0,1'b0,1'b1, 24'h000000, 1'b1},
    {7'd0,   16'hFFFF, 1'b1,1'b1,1'b1, 24'h00FFFF, 1'b0}
  };
  localparam string VTAG [NV] = '{"R1","R1 R3","R3","R4","R1 wrap","R5",
                                  "R6","R6","R3","R7","R7","R3 R4 R5"};

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_base = 0; cfg_len = 0;
    cfg_wprot = 0; cfg_nodma = 0; cfg_sysonly = 0;
    req_valid = 0; req_seg = 0; req_off = 0; req_write = 0; req_dma = 0; req_sys = 0;
    repeat (3) @(negedge clk);
    // R9: outputs low in reset
    chk("R9", {29'd0, rsp_valid, rsp_fwd, seg_trap}, 0);
    chk("R9", {8'd0, rsp_addr}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9: unwritten descriptor is base 0, length 0, no attributes
    issue(7'd1, 16'h0010, 1, 1, 0);
    expect_rsp("R9", 24'h000010, 0);
    issue(7'd1, 16'h0100, 0, 0, 0);
    expect_rsp("R9", 24'h000000, 1);

    wr_desc(6'd0,  16'h0000, 8'hFF, 0, 0, 0);
    wr_desc(6'd5,  16'h1234, 8'h0F, 1, 0, 0);
    wr_desc(6'd10, 16'hFFFF, 8'hFF, 0, 1, 0);
    wr_desc(6'd63, 16'h8000, 8'h00, 0, 0, 1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][50:44], VEC[i][43:28], VEC[i][27], VEC[i][26], VEC[i][25]);
      expect_rsp(VTAG[i], VEC[i][24:1], VEC[i][0]);
    end

    // R11: a cycle without request
    @(negedge clk);
    chk("R11", {29'd0, rsp_valid, rsp_fwd, seg_trap}, 0);

    // R2: back-to-back requests, each answered the next cycle
    @(negedge clk);
    req_valid = 1; req_seg = 0; req_off = 16'h0001; req_write = 0; req_dma = 0; req_sys = 0;
    @(negedge clk);
    chk("R2", {8'd0, rsp_addr}, 32'h000001);
    req_off = 16'h0002;
    @(negedge clk);
    req_valid = 0;
    chk("R2", {8'd0, rsp_addr}, 32'h000002);
    chk("R2", {31'd0, rsp_valid}, 1);

    // R10: write and request in the same cycle see the old descriptor
    @(negedge clk);
    cfg_we = 1; cfg_sel = 6'd5; cfg_base = 16'h0002; cfg_len = 8'hFF;
    cfg_wprot = 0; cfg_nodma = 0; cfg_sysonly = 0;
    req_valid = 1; req_seg = 7'd5; req_off = 16'h0001; req_write = 0;
    @(negedge clk);
    cfg_we = 0;
    chk("R10 old", {8'd0, rsp_addr}, 32'h123401);
    req_off = 16'h0301;
    @(negedge clk);
    req_valid = 0;
    chk("R10 new", {8'd0, rsp_addr}, 32'h000501);
    chk("R10 new", {31'd0, seg_trap}, 0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule